// File: doc/BRIEF.md
# Internal-Clock Single-Cycle Readout Sequencer

This block is the device-side serial readout controller of a converter that produces its own serial clock. The host uses one active-low select line both to control the device and to watch it. When the select falls, the block samples the level on the clock pin. It enters internal-clock mode only if that pin reads high, which is the case when it is floating against the weak pull-up or is driven high. The block then drives the clock pin low and places the end-of-conversion flag (EOC) on the data output. EOC is 1 while a conversion runs and 0 while the device sleeps with a result ready.

Once a result is ready, the block waits a fixed test window. During that window the host may deselect the device and send it back to sleep without losing the result. If the host keeps the select low, the block generates 32 clock periods. It shifts the result out MSB first and shifts the host's input word in. After the last period it pulses a start-conversion strobe and the flag goes back to 1. Deselecting at any point stops the clock and releases the data line.

Top module: `intclk_readout_seq`

## Requirements
- R1: Internal-clock mode is entered only when `sckSense` is 1 on the clock edge that first samples `csN` low. If it is 0, `sckOe` and `sdoOe` stay 0 and no `convStart` occurs until `csN` has gone high and fallen again. Changing `sckSense` while `csN` stays low has no effect.
- R2: Whenever `csN` is 1, both `sdoOe` and `sckOe` are 0.
- R3: In internal-clock mode with `csN` low and no frame shifting, `sckOe`=1, `sdoOe`=1, `sckOut`=0 and `sdoOut` is the EOC flag: 1 means converting, 0 means a result is ready.
- R4: While EOC is 1, holding `csN` low produces no `sckOut` rising edge. EOC goes to 0 on the clock edge that sees a 0-to-1 transition of `convDone`, and only then does the test window begin. With `csN` held low, a frame then follows with no new select fall.
- R5: When EOC is already 0, the first `sckOut` rise is registered TEST_CYCLES+HALF_DIV+1 clock edges after the edge that first samples `csN` low.
- R6: If `csN` returns high before the first `sckOut` rise, the block goes back to idle with no `convStart`. EOC stays 0, so the next select fall again reports 0 and a full frame follows.
- R7: `sckOut` has a half-period of HALF_DIV clocks (rises spaced 2*HALF_DIV clocks apart), and a completed frame holds exactly FRAME_BITS (32) rising edges.
- R8: `sdoOut` presents `resultWord` MSB first. Bit 31 is valid at the first rise, and each following bit appears on a falling edge of `sckOut`.
- R9: `sdi` is sampled on each rising edge of `sckOut`, MSB first. The assembled word appears on `rxWord` at the end of a completed frame.
- R10: HALF_DIV clocks after the 32nd rise, `sckOut` falls and `convStart` is 1 for exactly one cycle. In that cycle `sdoOut` is 1 (EOC) and `sckOut` is 0.
- R11: If `csN` goes high mid-frame, the clock stops and `sdoOe`/`sckOe` drop at once. No `convStart` follows and `rxWord` keeps its old value. The next select fall reports EOC=0 and restarts the frame from bit 31.
- R12: After reset, the block is idle with `sdoOe`=0, `sckOe`=0 and `convStart`=0, and EOC is 1 (a conversion is assumed in progress).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Host select, active low |
| sdi | input | 1 | Serial input data from host |
| sckSense | input | 1 | Sensed level of the clock pin (pulled up when undriven) |
| convDone | input | 1 | Conversion finished flag from the converter core |
| resultWord | input | FRAME_BITS | Conversion result to shift out |
| sckOut | output | 1 | Generated serial clock level |
| sckOe | output | 1 | Drive enable for the clock pin |
| sdoOut | output | 1 | Serial output data / EOC flag |
| sdoOe | output | 1 | Drive enable for the data pin (0 = high impedance) |
| convStart | output | 1 | One-cycle strobe starting the next conversion |
| rxWord | output | FRAME_BITS | Word received on `sdi` during the last completed frame |

## Verification
The assertions check the pin-release rule on every cycle: both drive enables are low whenever the select is high. They also check that each start strobe lasts one cycle, follows a high clock level and arrives with EOC high and the clock low, and that a clock rise is not followed by a one-cycle glitch. The bench scenarios cover behaviour that spans a whole frame or depends on earlier history. These are the exact latency to the first clock rise, the bit order on both data lines, an abort that leaves the result in place, mode rejection when the clock pin reads low, and a back-to-back frame that starts only after the conversion completes.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // deselected, outputs released
    ST_SKIP,   // select fell with clock pin low: not our mode
    ST_WAIT,   // reporting EOC, waiting for a ready result
    ST_TEST,   // test window before the first clock rise
    ST_SHIFT   // generating clock, shifting data
  } seqState_t;

  typedef struct packed {
    logic loadTx;    // capture result into output shifter
    logic shiftTx;   // advance output shifter (falling edge)
    logic sampleRx;  // take one SDI bit (rising edge)
    logic commitRx;  // publish received word (frame end)
  } dpStrobe_t;

endpackage

// File: rtl/rdseq_ctrl.sv
module rdseq_ctrl
  import rdseq_pkg::*;
#(
  parameter int FRAME_BITS  = 32,
  parameter int TEST_CYCLES = 16,
  parameter int HALF_DIV    = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      csN,
  input  logic      sckSense,
  input  logic      convDone,
  output dpStrobe_t strobe,
  output logic      sckLevel,
  output logic      convStart,
  output logic      eocLevel,
  output logic      driveEn,
  output logic      dataPhase
);

  localparam int TW = $clog2(TEST_CYCLES + 1);
  localparam int DW = $clog2(HALF_DIV + 1);
  localparam int BW = $clog2(FRAME_BITS + 1);

  seqState_t      state;
  logic [TW-1:0]  testCnt;
  logic [DW-1:0]  divCnt;
  logic [BW-1:0]  riseCnt;
  logic           csPrev;
  logic           doneQ;

  logic csFall, doneRise, halfDone, inShift;
  logic riseEv, fallEv, lastFall, testEnd;

  always_comb begin
    csFall   = csPrev & ~csN;
    doneRise = convDone & ~doneQ;
    inShift  = (state == ST_SHIFT);
    halfDone = (divCnt == DW'(HALF_DIV - 1));
    riseEv   = inShift & ~csN & halfDone & ~sckLevel;
    fallEv   = inShift & ~csN & halfDone & sckLevel;
    lastFall = fallEv & (riseCnt == BW'(FRAME_BITS));
    testEnd  = (state == ST_TEST) & ~csN & (testCnt == TW'(TEST_CYCLES - 1));

    strobe.loadTx   = testEnd;
    strobe.sampleRx = riseEv;
    strobe.shiftTx  = fallEv & ~lastFall;
    strobe.commitRx = lastFall;

    driveEn   = ~csN & ((state == ST_WAIT) | (state == ST_TEST) | inShift);
    dataPhase = inShift;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      testCnt   <= '0;
      divCnt    <= '0;
      riseCnt   <= '0;
      csPrev    <= 1'b1;
      doneQ     <= 1'b0;
      eocLevel  <= 1'b1;
      sckLevel  <= 1'b0;
      convStart <= 1'b0;
    end else begin
      csPrev    <= csN;
      doneQ     <= convDone;
      convStart <= 1'b0;

      if (lastFall)      eocLevel <= 1'b1;
      else if (doneRise) eocLevel <= 1'b0;

      if (csN) begin
        state    <= ST_IDLE;
        sckLevel <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (csFall) state <= sckSense ? ST_WAIT : ST_SKIP;
          end
          ST_SKIP: state <= ST_SKIP;
          ST_WAIT: begin
            if (!eocLevel) begin
              state   <= ST_TEST;
              testCnt <= '0;
            end
          end
          ST_TEST: begin
            if (testEnd) begin
              state    <= ST_SHIFT;
              divCnt   <= '0;
              riseCnt  <= '0;
              sckLevel <= 1'b0;
            end else begin
              testCnt <= testCnt + TW'(1);
            end
          end
          ST_SHIFT: begin
            if (halfDone) begin
              divCnt <= '0;
              if (!sckLevel) begin
                sckLevel <= 1'b1;
                riseCnt  <= riseCnt + BW'(1);
              end else begin
                sckLevel <= 1'b0;
                if (lastFall) begin
                  state     <= ST_WAIT;
                  convStart <= 1'b1;
                end
              end
            end else begin
              divCnt <= divCnt + DW'(1);
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/rdseq_data.sv
module rdseq_data
  import rdseq_pkg::*;
#(
  parameter int FRAME_BITS = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strobe,
  input  logic [FRAME_BITS-1:0] resultWord,
  input  logic                  sdi,
  output logic                  txBit,
  output logic [FRAME_BITS-1:0] rxWord
);

  localparam int MSB = FRAME_BITS - 1;

  logic [MSB:0] txShift;
  logic [MSB:0] rxShift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rxWord  <= '0;
    end else begin
      if (strobe.loadTx)        txShift <= resultWord;
      else if (strobe.shiftTx)  txShift <= {txShift[MSB-1:0], 1'b0};
      if (strobe.sampleRx)      rxShift <= {rxShift[MSB-1:0], sdi};
      if (strobe.commitRx)      rxWord  <= rxShift;
    end
  end

  assign txBit = txShift[MSB];

endmodule

// File: rtl/intclk_readout_seq.sv
module intclk_readout_seq
  import rdseq_pkg::*;
#(
  parameter int FRAME_BITS  = 32,
  parameter int TEST_CYCLES = 16,
  parameter int HALF_DIV    = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  csN,
  input  logic                  sdi,
  input  logic                  sckSense,
  input  logic                  convDone,
  input  logic [FRAME_BITS-1:0] resultWord,
  output logic                  sckOut,
  output logic                  sckOe,
  output logic                  sdoOut,
  output logic                  sdoOe,
  output logic                  convStart,
  output logic [FRAME_BITS-1:0] rxWord
);

  dpStrobe_t strobe;
  logic      sckLevel, eocLevel, driveEn, dataPhase, txBit;

  rdseq_ctrl #(
    .FRAME_BITS (FRAME_BITS),
    .TEST_CYCLES(TEST_CYCLES),
    .HALF_DIV   (HALF_DIV)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .csN      (csN),
    .sckSense (sckSense),
    .convDone (convDone),
    .strobe   (strobe),
    .sckLevel (sckLevel),
    .convStart(convStart),
    .eocLevel (eocLevel),
    .driveEn  (driveEn),
    .dataPhase(dataPhase)
  );

  rdseq_data #(
    .FRAME_BITS(FRAME_BITS)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .resultWord(resultWord),
    .sdi       (sdi),
    .txBit     (txBit),
    .rxWord    (rxWord)
  );

  assign sckOut = sckLevel;
  assign sckOe  = driveEn;
  assign sdoOe  = driveEn;
  assign sdoOut = dataPhase ? txBit : eocLevel;

endmodule

// File: rtl/rdseq_checker.sv
module rdseq_checker #(
  parameter int HALF_DIV = 4
) (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic sckOut,
  input logic sckOe,
  input logic sdoOut,
  input logic sdoOe,
  input logic convStart
);

  AST_SDO_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sdoOe);  // R2

  AST_SCK_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sckOe);  // R2

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);  // R10

  AST_START_EOC_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (convStart && !csN) |-> (sdoOut && !sckOut));  // R10

  AST_START_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> $past(sckOut));  // R10

  generate
    if (HALF_DIV >= 2) begin : gHalf
      AST_SCK_NO_GLITCH: assert property (@(posedge clk) disable iff (!rstN)
        ($rose(sckOut) && !csN) |=> (sckOut || csN));  // R7
    end
  endgenerate

endmodule

bind intclk_readout_seq rdseq_checker #(.HALF_DIV(HALF_DIV)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .csN      (csN),
  .sckOut   (sckOut),
  .sckOe    (sckOe),
  .sdoOut   (sdoOut),
  .sdoOe    (sdoOe),
  .convStart(convStart)
);

// File: tb/tb_intclk_readout_seq.sv
module tb_intclk_readout_seq;

  localparam int CLK_PERIOD = 10;
  localparam int FRAME      = 32;
  localparam int TESTC      = 6;
  localparam int HALF       = 2;
  localparam int NVEC       = 4;

  // {resultWord, sdi word}
  localparam logic [63:0] VEC [NVEC] = '{
    {32'hA5C3_0F96, 32'h1234_5678},
    {32'hFFFF_FFFF, 32'h0000_0000},
    {32'h0000_0000, 32'hFFFF_FFFF},
    {32'h8000_0001, 32'h7FFF_FFFE}
  };

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        rstN, csN, sdi, sckSense, convDone;
  logic [31:0] resultWord;
  logic        sckOut, sckOe, sdoOut, sdoOe, convStart;
  logic [31:0] rxWord;

  intclk_readout_seq #(
    .FRAME_BITS (FRAME),
    .TEST_CYCLES(TESTC),
    .HALF_DIV   (HALF)
  ) dut (
    .clk       (clk),
    .rstN      (rstN),
    .csN       (csN),
    .sdi       (sdi),
    .sckSense  (sckSense),
    .convDone  (convDone),
    .resultWord(resultWord),
    .sckOut    (sckOut),
    .sckOe     (sckOe),
    .sdoOut    (sdoOut),
    .sdoOe     (sdoOe),
    .convStart (convStart),
    .rxWord    (rxWord)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishConversion();
    @(negedge clk) convDone = 1'b1;
    repeat (2) @(negedge clk);
    convDone = 1'b0;
    @(negedge clk);
  endtask

  task automatic runFrame(input logic [31:0] sdiWord, input bit doFall,
                          input int abortAfter,
                          output logic [31:0] readWord, output int firstRise,
                          output int rises, output int starts,
                          output bit spacingOk, output logic sdoAtStart);
    int  cyc = 0;
    int  lastRise = -1;
    bit  prevSck;
    readWord = '0; firstRise = -1; rises = 0; starts = 0;
    spacingOk = 1'b1; sdoAtStart = 1'bx;
    @(negedge clk);
    if (doFall) csN = 1'b0;
    sdi = sdiWord[31];
    prevSck = sckOut;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) sdoAtStart = sdoOut;
      if (sckOut && !prevSck) begin
        if (rises == 0) firstRise = cyc;
        else if (cyc - lastRise != 2 * HALF) spacingOk = 1'b0;
        lastRise = cyc;
        readWord = {readWord[30:0], sdoOut};
        rises++;
      end
      prevSck = sckOut;
      if (!sckOut && rises < FRAME) sdi = sdiWord[31-rises];
      if (convStart) begin
        starts++;
        check(sdoOut == 1'b1 && sckOut == 1'b0, "R10 sdo high, sck low at start",
              {30'b0, sdoOut, sckOut}, 32'h2);
        break;
      end
      if (abortAfter != 0 && rises == abortAfter) begin
        csN = 1'b1;
        break;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, prevRx;
    int fr, nr, ns;
    bit spOk, bad;
    logic s0;

    rstN = 1'b0; csN = 1'b1; sdi = 1'b0; sckSense = 1'b1;
    convDone = 1'b0; resultWord = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R12 / R2: reset state
    check(sdoOe == 0 && sckOe == 0, "R12 enables after reset", {30'b0, sdoOe, sckOe}, 0);
    check(convStart == 0, "R12 no start after reset", {31'b0, convStart}, 0);

    // R3 / R12: select with conversion still running
    csN = 1'b0;
    repeat (2) @(negedge clk);
    check(sdoOe && sckOe && !sckOut && sdoOut, "R3 EOC=1 shown, sck low",
          {28'b0, sdoOe, sckOe, sckOut, sdoOut}, 32'hD);
    // R4: no clock while converting
    bad = 1'b0;
    repeat (30) begin
      @(negedge clk);
      if (sckOut || !sdoOut) bad = 1'b1;
    end
    check(!bad, "R4 no sck while EOC=1", {31'b0, bad}, 0);
    finishConversion();
    check(sdoOut == 0 && sckOut == 0, "R3 EOC=0 after done", {30'b0, sdoOut, sckOut}, 0);
    // R6: abort during test window
    csN = 1'b1;
    @(negedge clk);
    check(sdoOe == 0 && sckOe == 0, "R2 released on deselect", {30'b0, sdoOe, sckOe}, 0);
    bad = 1'b0;
    repeat (20) begin
      @(negedge clk);
      if (convStart || sckOut) bad = 1'b1;
    end
    check(!bad, "R6 no clock/start after early abort", {31'b0, bad}, 0);

    // Vector table: full frames
    for (int v = 0; v < NVEC; v++) begin
      resultWord = VEC[v][63:32];
      runFrame(VEC[v][31:0], 1'b1, 0, rd, fr, nr, ns, spOk, s0);
      check(s0 == 1'b0, "R6 EOC=0 reported at select", {31'b0, s0}, 0);
      check(rd == VEC[v][63:32], "R8 result bits", rd, VEC[v][63:32]);
      check(rxWord == VEC[v][31:0], "R9 received word", rxWord, VEC[v][31:0]);
      check(fr == TESTC + HALF + 2, "R5 first rise latency", fr, TESTC + HALF + 2);
      check(nr == FRAME && spOk, "R7 rise count and spacing", nr, FRAME);
      check(ns == 1, "R10 start strobe", ns, 1);
      @(negedge clk);
      check(convStart == 0, "R10 start one cycle", {31'b0, convStart}, 0);
      csN = 1'b1;
      finishConversion();
    end

    // R1: clock pin low at select fall
    @(negedge clk);
    sckSense = 1'b0;
    csN = 1'b0;
    bad = 1'b0;
    repeat (25) begin
      @(negedge clk);
      if (sdoOe || sckOe || convStart) bad = 1'b1;
    end
    check(!bad, "R1 ignored when pin low", {31'b0, bad}, 0);
    sckSense = 1'b1;
    bad = 1'b0;
    repeat (25) begin
      @(negedge clk);
      if (sdoOe || sckOe || convStart) bad = 1'b1;
    end
    check(!bad, "R1 late pin change ignored", {31'b0, bad}, 0);
    csN = 1'b1;
    @(negedge clk);

    // R11: abort mid-frame
    resultWord = 32'hC0DE_1234;
    prevRx = rxWord;
    runFrame(32'h0F0F_0F0F, 1'b1, 5, rd, fr, nr, ns, spOk, s0);
    @(negedge clk);
    check(sdoOe == 0 && sckOe == 0, "R11 released mid-frame", {30'b0, sdoOe, sckOe}, 0);
    bad = 1'b0;
    repeat (20) begin
      @(negedge clk);
      if (convStart) bad = 1'b1;
    end
    check(!bad, "R11 no start after abort", {31'b0, bad}, 0);
    check(rxWord == prevRx, "R11 rxWord kept", rxWord, prevRx);
    runFrame(32'h3C3C_A5A5, 1'b1, 0, rd, fr, nr, ns, spOk, s0);
    check(s0 == 1'b0, "R11 EOC still 0 after abort", {31'b0, s0}, 0);
    check(rd == 32'hC0DE_1234, "R11 frame restarts at MSB", rd, 32'hC0DE_1234);
    check(rxWord == 32'h3C3C_A5A5, "R9 rx after restart", rxWord, 32'h3C3C_A5A5);

    // R4: select held low across conversion
    bad = 1'b0;
    repeat (20) begin
      @(negedge clk);
      if (sckOut || !sdoOut) bad = 1'b1;
    end
    check(!bad, "R4 holds while converting", {31'b0, bad}, 0);
    resultWord = 32'h5A5A_0FF0;
    finishConversion();
    runFrame(32'hDEAD_BEEF, 1'b0, 0, rd, fr, nr, ns, spOk, s0);
    check(rd == 32'h5A5A_0FF0 && nr == FRAME, "R4 frame after done", rd, 32'h5A5A_0FF0);
    check(rxWord == 32'hDEAD_BEEF, "R9 rx back-to-back", rxWord, 32'hDEAD_BEEF);
    csN = 1'b1;
    @(negedge clk);
    check(sdoOe == 0, "R2 released at end", {31'b0, sdoOe}, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule